// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This block sends frames that software has placed in memory. Software builds a linked list of descriptors, writes the address of the first one to the head register and sets the start bit. The engine then walks the list, one descriptor at a time, and keeps a single request open on a simple request/acknowledge memory port. For every descriptor that holds a frame, it fetches the payload and presents the bytes on a byte stream that uses valid/ready flow control. It then sets the descriptor's empty flag again in memory, adds one to the sent-frame count and follows the next pointer.

When the loopback configuration bit is set, the bytes go to a loopback stream and the transmit stream stays idle. The loopback setting is sampled once, when a run starts. A run ends at the first descriptor that is already empty. At that point the engine raises the underrun flag and clears its own enable.

The block does no line framing, preamble, CRC or inter-frame timing.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, `dma_en`, `sent_cnt`, `sent_flag`, `underrun_flag`, `mem_req`, `tx_valid` and `lb_valid` are all 0.
- R2: Register writes select a register with `reg_sel`:
  - 0 is configuration: bit 0 is transmit enable, bit 8 is loopback.
  - 1 is the head address.
  - 2 is control: bit 0 is start.
  - 3 is status clear, write-one-to-clear: bit 0 clears `sent_flag`, bit 1 clears `underrun_flag`.

  A start write while the transmit-enable bit is 0 has no effect: `dma_en` stays 0 and no memory request is made.
- R3: The head register forces its two low bits to zero. The first descriptor read of a run therefore goes to the written value with bits 1:0 cleared.
- R4: A descriptor is three 32-bit words at D, D+4 and D+8:
  - the word at D is the buffer address;
  - the word at D+4 is the size word, with bit 31 as the empty flag and bits 10:0 as the byte length;
  - the word at D+8 is the next-descriptor address.

  Memory is little-endian: the byte at address A sits in bits 8*(A mod 4)+7 down to 8*(A mod 4) of its word. The bytes leave in address order from any start alignment, and the last marker is high on the final byte only.
- R5: While a run started with loopback set, every byte appears on the `lb_*` stream and `tx_valid` stays 0. The two valids are never high together.
- R6: After the last byte of a frame is accepted, the engine writes the size word back to D+4 with bit 31 set and all other bits unchanged.
- R7: Each completed frame adds exactly 1 to `sent_cnt` and sets `sent_flag`.
- R8: The engine follows each next pointer. At a descriptor whose empty flag is set, the run ends: `underrun_flag` is set, `dma_en` drops, and neither D+8 of that descriptor nor any payload is read.
- R9: Only one memory request is open at a time. `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack`.
- R10: A descriptor of length 0 sends no bytes, but it is still written back and counted.
- R11: While a stream's valid is high and its ready is low, its data and last marker hold steady.
- R12: A start write that lands in the cycle in which a run ends begins a new run at the current head address. In that case `underrun_flag` is set and `dma_en` stays 1.
- R13: A status-clear write clears the selected flags and leaves `sent_cnt` unchanged. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 config, 1 head, 2 control, 3 status clear) |
| reg_wdata | input | 32 | Register write data |
| dma_en | output | 1 | Engine enable; high while a run is in progress |
| sent_cnt | output | CNT_W | Count of completed frames |
| sent_flag | output | 1 | Set when a frame completes |
| underrun_flag | output | 1 | Set when a run reaches an empty descriptor |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Transmit sink ready |
| lb_data | output | 8 | Loopback byte |
| lb_valid | output | 1 | Loopback byte valid |
| lb_last | output | 1 | Final loopback byte of a frame |
| lb_ready | input | 1 | Loopback sink ready |

## Verification
Two things can happen in the same cycle: a run ending (underrun set, enable cleared) and a software start request. To provoke this, the memory model watches for the read of the terminating descriptor's size word. It then places the start write in the next clock cycle, which is exactly the finishing cycle. The outcome is judged by three observations:
- `underrun_flag` is high while `dma_en` is still high;
- the bytes of the second chain, which begins at a head address rewritten during the first run, reach the scoreboard in order;
- the frame count covers both runs.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_PREAD,
    ST_POUT,
    ST_WBACK,
    ST_FINISH
  } txd_state_e;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
  localparam logic [1:0] SEL_CLR  = 2'd3;

  localparam int EMPTY_BIT = 31;
  localparam int CFG_TXEN_BIT = 0;
  localparam int CFG_LOOP_BIT = 8;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic             eng_can_start,
  input  logic             eng_frame_done,
  input  logic             eng_run_end,
  output logic             start_go,
  output logic [AW-1:0]    head_addr,
  output logic             loop_en,
  output logic             dma_en,
  output logic [CNT_W-1:0] sent_cnt,
  output logic             sent_flag,
  output logic             underrun_flag
);
  logic             txen_q, txen_d;
  logic             loop_q, loop_d;
  logic [AW-1:0]    head_q, head_d;
  logic             en_q, en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sent_q, sent_d;
  logic             und_q, und_d;
  logic             wr_cfg, wr_head, wr_ctl, wr_clr;

  always_comb begin
    wr_cfg   = reg_wr && (reg_sel == SEL_CFG);
    wr_head  = reg_wr && (reg_sel == SEL_HEAD);
    wr_ctl   = reg_wr && (reg_sel == SEL_CTL);
    wr_clr   = reg_wr && (reg_sel == SEL_CLR);
    start_go = wr_ctl && reg_wdata[0] && txen_q && eng_can_start;
  end

  always_comb begin
    txen_d = txen_q;
    loop_d = loop_q;
    head_d = head_q;
    en_d   = en_q;
    cnt_d  = cnt_q;
    sent_d = sent_q;
    und_d  = und_q;
    if (wr_cfg) begin
      txen_d = reg_wdata[CFG_TXEN_BIT];
      loop_d = reg_wdata[CFG_LOOP_BIT];
    end
    if (wr_head) begin
      head_d = {reg_wdata[AW-1:2], 2'b00};
    end
    if (start_go) begin
      en_d = 1'b1;
    end else if (eng_run_end) begin
      en_d = 1'b0;
    end
    if (eng_frame_done) begin
      cnt_d  = cnt_q + CNT_W'(1);
      sent_d = 1'b1;
    end else if (wr_clr && reg_wdata[0]) begin
      sent_d = 1'b0;
    end
    if (eng_run_end) begin
      und_d = 1'b1;
    end else if (wr_clr && reg_wdata[1]) begin
      und_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen_q <= 1'b0;
      loop_q <= 1'b0;
      head_q <= '0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
      sent_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      txen_q <= txen_d;
      loop_q <= loop_d;
      head_q <= head_d;
      en_q   <= en_d;
      cnt_q  <= cnt_d;
      sent_q <= sent_d;
      und_q  <= und_d;
    end
  end

  assign head_addr     = head_q;
  assign loop_en       = loop_q;
  assign dma_en        = en_q;
  assign sent_cnt      = cnt_q;
  assign sent_flag     = sent_q;
  assign underrun_flag = und_q;
endmodule

// File: rtl/txd_walk.sv
module txd_walk
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_go,
  input  logic [AW-1:0] head_addr,
  input  logic          loop_en,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    byte_data,
  output logic          byte_valid,
  output logic          byte_last,
  input  logic          byte_ready,
  output logic          loop_sel,
  output logic          can_start,
  output logic          frame_done,
  output logic          run_end
);
  txd_state_e       st_q, st_d;
  logic [1:0]       widx_q, widx_d;
  logic [AW-1:0]    cur_q, cur_d;
  logic [AW-1:0]    buf_q, buf_d;
  logic [AW-1:0]    nxt_q, nxt_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [31:0]      size_q, size_d;
  logic [31:0]      word_q, word_d;
  logic             lb_q, lb_d;

  always_comb begin
    st_d   = st_q;
    widx_d = widx_q;
    cur_d  = cur_q;
    buf_d  = buf_q;
    nxt_d  = nxt_q;
    rem_d  = rem_q;
    size_d = size_q;
    word_d = word_q;
    lb_d   = lb_q;
    unique case (st_q)
      ST_IDLE, ST_FINISH: begin
        if (start_go) begin
          cur_d  = head_addr;
          lb_d   = loop_en;
          widx_d = 2'd0;
          st_d   = ST_DESC;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_DESC: begin
        if (mem_ack) begin
          unique case (widx_q)
            2'd0: begin
              buf_d  = mem_rdata[AW-1:0];
              widx_d = 2'd1;
            end
            2'd1: begin
              if (mem_rdata[EMPTY_BIT]) begin
                st_d = ST_FINISH;
              end else begin
                size_d = mem_rdata;
                rem_d  = mem_rdata[LEN_W-1:0];
                widx_d = 2'd2;
              end
            end
            default: begin
              nxt_d = mem_rdata[AW-1:0];
              st_d  = (rem_q == '0) ? ST_WBACK : ST_PREAD;
            end
          endcase
        end
      end
      ST_PREAD: begin
        if (mem_ack) begin
          word_d = mem_rdata;
          st_d   = ST_POUT;
        end
      end
      ST_POUT: begin
        if (byte_ready) begin
          buf_d = buf_q + AW'(1);
          rem_d = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) begin
            st_d = ST_WBACK;
          end else if (buf_q[1:0] == 2'b11) begin
            st_d = ST_PREAD;
          end
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          cur_d  = nxt_q;
          widx_d = 2'd0;
          st_d   = ST_DESC;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      widx_q <= 2'd0;
      cur_q  <= '0;
      buf_q  <= '0;
      nxt_q  <= '0;
      rem_q  <= '0;
      size_q <= '0;
      word_q <= '0;
      lb_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      widx_q <= widx_d;
      cur_q  <= cur_d;
      buf_q  <= buf_d;
      nxt_q  <= nxt_d;
      rem_q  <= rem_d;
      size_q <= size_d;
      word_q <= word_d;
      lb_q   <= lb_d;
    end
  end

  always_comb begin
    mem_req   = (st_q == ST_DESC) || (st_q == ST_PREAD) || (st_q == ST_WBACK);
    mem_we    = (st_q == ST_WBACK);
    mem_wdata = size_q | (32'd1 << EMPTY_BIT);
    unique case (st_q)
      ST_PREAD: mem_addr = {buf_q[AW-1:2], 2'b00};
      ST_WBACK: mem_addr = cur_q + AW'(4);
      default:  mem_addr = cur_q + AW'({widx_q, 2'b00});
    endcase
  end

  always_comb begin
    unique case (buf_q[1:0])
      2'd0:    byte_data = word_q[7:0];
      2'd1:    byte_data = word_q[15:8];
      2'd2:    byte_data = word_q[23:16];
      default: byte_data = word_q[31:24];
    endcase
    byte_valid = (st_q == ST_POUT);
    byte_last  = (rem_q == LEN_W'(1));
    loop_sel   = lb_q;
    can_start  = (st_q == ST_IDLE) || (st_q == ST_FINISH);
    frame_done = (st_q == ST_WBACK) && mem_ack;
    run_end    = (st_q == ST_FINISH);
  end
endmodule

// File: rtl/txd_route.sv
module txd_route #(
  parameter int NLANE = 2
) (
  input  logic       sel,
  input  logic [7:0] b_data,
  input  logic       b_valid,
  input  logic       b_last,
  output logic       b_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  output logic       tx_last,
  input  logic       tx_ready,
  output logic [7:0] lb_data,
  output logic       lb_valid,
  output logic       lb_last,
  input  logic       lb_ready
);
  logic [NLANE-1:0] vld;
  logic [NLANE-1:0] rdy;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign vld[g] = b_valid && (sel == (g != 0));
  end

  assign rdy      = {lb_ready, tx_ready};
  assign b_ready  = rdy[sel];
  assign tx_valid = vld[0];
  assign lb_valid = vld[1];
  assign tx_data  = b_data;
  assign lb_data  = b_data;
  assign tx_last  = b_last && !sel;
  assign lb_last  = b_last && sel;
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic             dma_en,
  output logic [CNT_W-1:0] sent_cnt,
  output logic             sent_flag,
  output logic             underrun_flag,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  input  logic             tx_ready,
  output logic [7:0]       lb_data,
  output logic             lb_valid,
  output logic             lb_last,
  input  logic             lb_ready
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          start_go, loop_en, loop_sel;
  logic          can_start, frame_done, run_end;
  logic [AW-1:0] head_addr;
  logic [7:0]    b_data;
  logic          b_valid, b_last, b_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  txd_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .reg_wr         (reg_wr),
    .reg_sel        (reg_sel),
    .reg_wdata      (reg_wdata),
    .eng_can_start  (can_start),
    .eng_frame_done (frame_done),
    .eng_run_end    (run_end),
    .start_go       (start_go),
    .head_addr      (head_addr),
    .loop_en        (loop_en),
    .dma_en         (dma_en),
    .sent_cnt       (sent_cnt),
    .sent_flag      (sent_flag),
    .underrun_flag  (underrun_flag)
  );

  txd_walk #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_go   (start_go),
    .head_addr  (head_addr),
    .loop_en    (loop_en),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .byte_data  (b_data),
    .byte_valid (b_valid),
    .byte_last  (b_last),
    .byte_ready (b_ready),
    .loop_sel   (loop_sel),
    .can_start  (can_start),
    .frame_done (frame_done),
    .run_end    (run_end)
  );

  txd_route #(.NLANE(2)) u_route (
    .sel      (loop_sel),
    .b_data   (b_data),
    .b_valid  (b_valid),
    .b_last   (b_last),
    .b_ready  (b_ready),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .lb_data  (lb_data),
    .lb_valid (lb_valid),
    .lb_last  (lb_last),
    .lb_ready (lb_ready)
  );
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk #(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_en,
  input logic [CNT_W-1:0] sent_cnt,
  input logic             underrun_flag,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             mem_ack,
  input logic [7:0]       tx_data,
  input logic             tx_valid,
  input logic             tx_last,
  input logic             tx_ready,
  input logic [7:0]       lb_data,
  input logic             lb_valid,
  input logic             lb_last,
  input logic             lb_ready
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R11

  AST_LB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_valid && !lb_ready) |=> (lb_valid && $stable(lb_data) && $stable(lb_last))); // R11

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && lb_valid)); // R5

  AST_WB_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[31]); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_cnt != $past(sent_cnt)) |-> (sent_cnt == $past(sent_cnt) + CNT_W'(1))); // R7

  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_en) |-> underrun_flag); // R8
endmodule

bind txdesc_dma txdesc_dma_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/txdesc_dma_tb.sv
`timescale 1ns/1ps
module txdesc_dma_tb;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        dma_en;
  logic [7:0]  sent_cnt;
  logic        sent_flag, underrun_flag;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data, lb_data;
  logic        tx_valid, tx_last, tx_ready;
  logic        lb_valid, lb_last, lb_ready;

  txdesc_dma u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [0:1023];
  int rd_hits [0:1023];
  int grants = 0;
  int wait_cnt = 0;
  int lat = 0;
  logic [31:0] held_addr;
  logic        held_we;
  logic [31:0] held_wdata;
  bit cap_first = 0;
  logic [31:0] first_addr = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFFF;
  bit term_hit = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt > 0) begin
        check(mem_addr == held_addr && mem_we == held_we && mem_wdata == held_wdata,
              "R9 request held", int'(mem_addr), int'(held_addr));
      end
      held_addr = mem_addr;
      held_we = mem_we;
      held_wdata = mem_wdata;
      if (wait_cnt < lat) begin
        wait_cnt++;
      end else begin
        wait_cnt = 0;
        lat = (lat + 1) % 3;
        mem_ack = 1'b1;
        grants++;
        if (cap_first) begin
          first_addr = mem_addr;
          cap_first = 0;
        end
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
          rd_hits[mem_addr[11:2]]++;
          if (mem_addr == watch_addr) term_hit = 1;
        end
      end
    end
  end

  // scoreboard
  typedef struct { logic [7:0] d; logic last; logic lb; } exp_t;
  exp_t q[$];
  bit stall_en = 0;
  logic [7:0] lfsr = 8'h5A;
  bit prev_stall = 0;
  logic [7:0] prev_d;
  logic prev_last;

  always @(negedge clk) begin
    if (!rst_n) begin
      tx_ready = 1'b1;
      lb_ready = 1'b1;
      prev_stall = 0;
    end else begin
      if (prev_stall) begin
        check((tx_valid || lb_valid) && (tx_valid ? tx_data : lb_data) == prev_d &&
              (tx_valid ? tx_last : lb_last) == prev_last,
              "R11 held while stalled", int'(tx_valid ? tx_data : lb_data), int'(prev_d));
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready = stall_en ? lfsr[0] : 1'b1;
      lb_ready = stall_en ? lfsr[1] : 1'b1;
      check(!(tx_valid && lb_valid), "R5 both valid", 1, 0);
      if ((tx_valid && tx_ready) || (lb_valid && lb_ready)) begin
        if (q.size() == 0) begin
          check(0, "R4 unexpected byte", int'(tx_valid ? tx_data : lb_data), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(lb_valid == e.lb, "R5 stream select", int'(lb_valid), int'(e.lb));
          check((lb_valid ? lb_data : tx_data) == e.d, "R4 byte", int'(lb_valid ? lb_data : tx_data), int'(e.d));
          check((lb_valid ? lb_last : tx_last) == e.last, "R4 last", int'(lb_valid ? lb_last : tx_last), int'(e.last));
        end
      end
      prev_stall = (tx_valid && !tx_ready) || (lb_valid && !lb_ready);
      prev_d = tx_valid ? tx_data : lb_data;
      prev_last = tx_valid ? tx_last : lb_last;
    end
  end

  // driver tasks
  task automatic put_byte(input int a, input logic [7:0] v);
    mem[a >> 2][8*(a % 4) +: 8] = v;
  endtask

  task automatic build_frame(input int d, input int b, input int len, input int nxt,
                             input int seed, input bit lb);
    mem[d >> 2] = b;
    mem[(d >> 2) + 1] = len;
    mem[(d >> 2) + 2] = nxt;
    for (int i = 0; i < len; i++) begin
      exp_t e;
      e.d = 8'((seed + i * 7) & 255);
      e.last = (i == len - 1);
      e.lb = lb;
      put_byte(b + i, e.d);
      q.push_back(e);
    end
  endtask

  task automatic build_empty(input int d);
    mem[d >> 2] = 32'h0;
    mem[(d >> 2) + 1] = 32'h8000_0000;
    mem[(d >> 2) + 2] = 32'h0;
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_sel = sel;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while ((dma_en || q.size() != 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g0;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'h0;
      rd_hits[i] = 0;
    end
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_sel = 2'd0;
    reg_wdata = 32'h0;
    mem_rdata = 32'h0;
    mem_ack = 1'b0;
    tx_ready = 1'b1;
    lb_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!dma_en && sent_cnt == 0 && !sent_flag && !underrun_flag, "R1 status reset",
          int'({dma_en, sent_flag, underrun_flag}), 0);
    check(!mem_req && !tx_valid && !lb_valid, "R1 outputs idle",
          int'({mem_req, tx_valid, lb_valid}), 0);

    // R2 start ignored while transmit enable is clear
    g0 = grants;
    reg_write(2'd1, 32'h0000_0100);
    reg_write(2'd2, 32'h1);
    repeat (10) @(negedge clk);
    check(!dma_en, "R2 start gated by tx enable", int'(dma_en), 0);
    check(grants == g0 && !mem_req, "R2 no memory access", grants - g0, 0);

    // R3 R4 R6 R7 R8 R10 normal chain with stalls
    build_frame(32'h100, 32'h401, 5, 32'h110, 8'h11, 0);
    build_frame(32'h110, 32'h500, 8, 32'h120, 8'h40, 0);
    build_frame(32'h120, 32'h580, 0, 32'h130, 8'h00, 0);
    build_empty(32'h130);
    stall_en = 1;
    reg_write(2'd0, 32'h1);
    reg_write(2'd1, 32'h103);
    cap_first = 1;
    reg_write(2'd2, 32'h1);
    check(dma_en, "R8 enable set at start", int'(dma_en), 1);
    wait_end();
    check(first_addr == 32'h100, "R3 head low bits cleared", int'(first_addr), 32'h100);
    check(q.size() == 0, "R4 all bytes sent", q.size(), 0);
    check(mem[32'h104 >> 2] == 32'h8000_0005, "R6 writeback 1", int'(mem[32'h104 >> 2]), 32'h8000_0005);
    check(mem[32'h114 >> 2] == 32'h8000_0008, "R6 writeback 2", int'(mem[32'h114 >> 2]), 32'h8000_0008);
    check(mem[32'h124 >> 2] == 32'h8000_0000, "R10 zero length written back", int'(mem[32'h124 >> 2]), 32'h8000_0000);
    check(sent_cnt == 3, "R7 R10 count", int'(sent_cnt), 3);
    check(sent_flag, "R7 sent flag", int'(sent_flag), 1);
    check(underrun_flag && !dma_en, "R8 run end", int'({underrun_flag, dma_en}), 2);
    check(rd_hits[(32'h130 + 8) >> 2] == 0, "R8 next of empty not read", rd_hits[(32'h130 + 8) >> 2], 0);
    check(rd_hits[32'h580 >> 2] == 0, "R10 no payload read", rd_hits[32'h580 >> 2], 0);

    // R13 status clear
    reg_write(2'd3, 32'h3);
    @(negedge clk);
    check(!sent_flag && !underrun_flag && sent_cnt == 3, "R13 clear flags keep count",
          int'({sent_flag, underrun_flag}), 0);

    // R5 loopback
    build_frame(32'h200, 32'h600, 3, 32'h210, 8'h77, 1);
    build_empty(32'h210);
    reg_write(2'd0, 32'h101);
    reg_write(2'd1, 32'h200);
    reg_write(2'd2, 32'h1);
    wait_end();
    check(q.size() == 0 && sent_cnt == 4, "R5 loopback frame", int'(sent_cnt), 4);

    // R12 start in the finishing cycle
    reg_write(2'd3, 32'h3);
    stall_en = 0;
    build_frame(32'h300, 32'h700, 2, 32'h310, 8'h21, 0);
    build_empty(32'h310);
    build_frame(32'h340, 32'h781, 4, 32'h350, 8'h93, 0);
    build_empty(32'h350);
    reg_write(2'd0, 32'h1);
    reg_write(2'd1, 32'h300);
    watch_addr = 32'h314;
    term_hit = 0;
    reg_write(2'd2, 32'h1);
    reg_write(2'd1, 32'h340);
    wait (term_hit == 1);
    reg_write(2'd2, 32'h1);
    check(underrun_flag && dma_en, "R12 restart keeps enable", int'({underrun_flag, dma_en}), 3);
    wait_end();
    check(q.size() == 0 && sent_cnt == 6, "R12 second chain sent", int'(sent_cnt), 6);
    check(mem[32'h344 >> 2] == 32'h8000_0004, "R12 second writeback", int'(mem[32'h344 >> 2]), 32'h8000_0004);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule